// File: doc/BRIEF.md
# Configurable Byte-Wide SPI Port

This block is a byte-wide serial peripheral port that works either as an SPI master or as an SPI slave. A four-bit role field selects the role and, for the master, where the serial clock comes from: one of three fixed dividers of the system clock, or an external timer tick. The CPU sees three registers on a small register bus. The control register holds the role field, the clock polarity and an enable. The buffer register is written to transmit and read to receive. The status register holds a buffer-full bit and two sticky error flags.

Every transfer is exactly eight bits, most significant bit first. The port drives its output bit when the clock leaves its idle level and samples its input bit when the clock returns to idle. When a byte completes, the received byte lands in the buffer, buffer-full is set and `done` pulses for one cycle. In the master role a transfer starts only when the CPU writes the buffer. In the slave role the port follows an external clock, with an optional active-low select pin. Writing the buffer while a byte is shifting is refused and flags a collision. A slave byte that completes while the buffer still holds an unread byte is dropped and flags an overflow.

Top module: `spi_port`

## Requirements
- R1: With roles 0000, 0001 and 0010 and the port enabled, a master transfer takes 8×DIV system clocks from the clock edge that captures the buffer write to the clock edge that raises `done`. DIV is DIV_FAST, DIV_MID or DIV_SLOW respectively, and SCK changes level every DIV/2 clocks.
- R2: With role 0011, SCK changes level once per system clock in which `timer_tick` is high. It therefore runs at half the tick rate and does not move while no tick arrives.
- R3: Control bit 4 is the clock polarity. While the port is idle, `sck_o` equals that bit. `sck_oe` is high exactly when the port is enabled in a master role.
- R4: A transfer shifts 8 bits, MSB first. The output bit changes when SCK leaves idle and the input bit is sampled when SCK returns to idle. A master transfer produces 16 SCK transitions and leaves the received byte in the buffer.
- R5: At the end of every byte, `done` is high for exactly one cycle and status bit 0 (buffer full) is set. Reading the buffer (address 1) clears status bit 0.
- R6: A buffer write while a byte is shifting is ignored, and the byte in progress continues unchanged. The write sets status bit 2 (collision), which stays set until status is written with bit 2 at 1.
- R7: In a slave role, if a byte completes while status bit 0 is set, that byte is discarded and the buffer keeps the earlier one. Status bit 1 (overflow) is then set and stays set until status is written with bit 1 at 1. Only a buffer read empties the buffer.
- R8: Status bit 1 is never set while the port is in a master role, even when received bytes are never read.
- R9: With role 0100, `ss_n` high keeps `sdo_oe` low and the slave idle, so SCK activity is ignored. Raising `ss_n` in the middle of a byte discards the partial byte, and the next selection starts a fresh byte.
- R10: With role 0101, `ss_n` is ignored and the slave is always selected, so `sdo_oe` is high.
- R11: With control bit 5 (enable) at 0, or with a role code above 0101, `port_en`, `sck_oe` and `sdo_oe` are low. No transfer runs, and a buffer write made in that state does not start one later.
- R12: Register map: address 0 is control {enable bit 5, polarity bit 4, role bits 3:0}, address 1 is the buffer, and address 2 is status {collision bit 2, overflow bit 1, full bit 0}. All registers read as 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears full on buffer read) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data, combinational |
| timer_tick | input | 1 | External tick for role 0011 |
| sck_i | input | 1 | Serial clock input (slave) |
| sck_o | output | 1 | Serial clock output (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |
| ss_n | input | 1 | Slave select, active low |
| port_en | output | 1 | High while the port owns its pins |
| done | output | 1 | One-cycle end-of-byte pulse |

## Verification
The bench builds the port with DIV_FAST=4, DIV_MID=8 and DIV_SLOW=16. This keeps each master byte short enough to run many byte patterns with both clock polarities. It also keeps the three dividers distinct, so an exact cycle count of 32, 64 or 128 clocks tells the roles apart. The slave is driven with an SCK half period of eight system clocks, which is well inside the synchronizer's limit. The bench aims bytes at the overflow, collision, deselect-abort and disabled-port cases.

// File: rtl/spi_port.sv
module spi_port #(
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 16,
  parameter int DIV_SLOW = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       timer_tick,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       sdi,
  output logic       sdo,
  output logic       sdo_oe,
  input  logic       ss_n,
  output logic       port_en,
  output logic       done
);
  localparam int HALF_F = DIV_FAST / 2;
  localparam int HALF_M = DIV_MID / 2;
  localparam int HALF_S = DIV_SLOW / 2;
  localparam int CW = (HALF_S > 1) ? $clog2(HALF_S) : 1;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_BUF  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  logic [3:0]    ctrl_mode;
  logic          ctrl_cpol, ctrl_en;
  logic [7:0]    sh, buf_q;
  logic          out_bit, busy, phase, bf, ovf, wcol;
  logic [2:0]    bitcnt;
  logic [CW-1:0] div_cnt, half_lim;
  logic [2:0]    sck_sync;
  logic [1:0]    ss_sync;

  logic active, is_master, is_slave, sel;
  logic buf_wr, buf_rd, stat_wr, ctrl_wr;
  logic half_tick, lead, trail, last, edge_s;
  logic load_ok, collide;
  logic [7:0] rx_byte;

  assign active    = ctrl_en && (ctrl_mode <= 4'd5);
  assign is_master = active && (ctrl_mode[3:2] == 2'b00);
  assign is_slave  = active && ctrl_mode[2];
  assign sel       = ctrl_mode[0] || !ss_sync[1];

  assign ctrl_wr = wr_en && (addr == A_CTRL);
  assign buf_wr  = wr_en && (addr == A_BUF);
  assign stat_wr = wr_en && (addr == A_STAT);
  assign buf_rd  = rd_en && (addr == A_BUF);

  always_comb begin
    case (ctrl_mode[1:0])
      2'b00:   half_lim = CW'(HALF_F - 1);
      2'b01:   half_lim = CW'(HALF_M - 1);
      default: half_lim = CW'(HALF_S - 1);
    endcase
  end

  assign half_tick = is_master && busy &&
                     ((ctrl_mode[1:0] == 2'b11) ? timer_tick : (div_cnt == half_lim));
  assign edge_s    = is_slave && sel && (sck_sync[1] != sck_sync[2]);

  assign lead  = (half_tick && !phase) || (edge_s && (sck_sync[2] == ctrl_cpol));
  assign trail = (half_tick && phase)  || (edge_s && busy && (sck_sync[1] == ctrl_cpol));
  assign last  = trail && (bitcnt == 3'd7);

  assign rx_byte = {sh[6:0], sdi};
  assign load_ok = buf_wr && active && !busy;
  assign collide = buf_wr && active && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_mode <= '0;
      ctrl_cpol <= 1'b0;
      ctrl_en   <= 1'b0;
      sh        <= '0;
      buf_q     <= '0;
      out_bit   <= 1'b0;
      busy      <= 1'b0;
      phase     <= 1'b0;
      bf        <= 1'b0;
      ovf       <= 1'b0;
      wcol      <= 1'b0;
      bitcnt    <= '0;
      div_cnt   <= '0;
      sck_sync  <= '0;
      ss_sync   <= 2'b11;
      done      <= 1'b0;
    end else begin
      done     <= 1'b0;
      sck_sync <= {sck_sync[1:0], sck_i};
      ss_sync  <= {ss_sync[0], ss_n};

      if (ctrl_wr) {ctrl_en, ctrl_cpol, ctrl_mode} <= wdata[5:0];
      if (stat_wr && wdata[1]) ovf <= 1'b0;
      if (stat_wr && wdata[2]) wcol <= 1'b0;
      if (buf_rd) bf <= 1'b0;
      if (collide) wcol <= 1'b1;

      if (is_master && busy)
        div_cnt <= (div_cnt == half_lim) ? '0 : div_cnt + CW'(1);
      if (half_tick) phase <= !phase;

      if (load_ok) begin
        sh      <= wdata;
        out_bit <= wdata[7];
        bitcnt  <= '0;
        if (is_master) begin
          busy    <= 1'b1;
          phase   <= 1'b0;
          div_cnt <= '0;
        end
      end

      if (lead) begin
        out_bit <= sh[7];
        if (is_slave) busy <= 1'b1;
      end

      if (trail) begin
        sh     <= rx_byte;
        bitcnt <= bitcnt + 3'd1;
      end

      if (last) begin
        busy  <= 1'b0;
        phase <= 1'b0;
        done  <= 1'b1;
        if (is_slave && bf && !buf_rd) begin
          ovf <= 1'b1;
        end else begin
          buf_q <= rx_byte;
          bf    <= 1'b1;
        end
      end

      if (!active || (is_slave && !sel)) begin
        busy   <= 1'b0;
        phase  <= 1'b0;
        bitcnt <= '0;
      end
    end
  end

  assign sck_o   = ctrl_cpol ^ (is_master && busy && phase);
  assign sck_oe  = is_master;
  assign sdo     = out_bit;
  assign sdo_oe  = is_master || (is_slave && sel);
  assign port_en = active;

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {2'b00, ctrl_en, ctrl_cpol, ctrl_mode};
      A_BUF:   rdata = buf_q;
      A_STAT:  rdata = {5'b0, wcol, ovf, bf};
      default: rdata = 8'h00;
    endcase
  end
endmodule

module spi_port_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic       ss_n,
  input logic       done,
  input logic       port_en,
  input logic       sck_oe,
  input logic       sdo_oe,
  input logic [3:0] ctrl_mode,
  input logic       ctrl_en,
  input logic       ovf,
  input logic       wcol
);
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_wcol_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wcol && !(wr_en && addr == 2'd2 && wdata[2])) |=> wcol);

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(wr_en && addr == 2'd2 && wdata[1])) |=> ovf);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && ctrl_mode[3:2] == 2'b00 && !ovf) |=> !ovf);

  p_ss_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && ctrl_mode == 4'd4 && ss_n && $past(ss_n) && $past(ss_n, 2)) |-> !sdo_oe);

  p_pins_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> (!sck_oe && !sdo_oe));
endmodule

bind spi_port spi_port_checker u_spi_port_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .addr      (addr),
  .wdata     (wdata),
  .ss_n      (ss_n),
  .done      (done),
  .port_en   (port_en),
  .sck_oe    (sck_oe),
  .sdo_oe    (sdo_oe),
  .ctrl_mode (ctrl_mode),
  .ctrl_en   (ctrl_en),
  .ovf       (ovf),
  .wcol      (wcol)
);

// File: tb/spi_port_bench.sv
module spi_port_bench;
  localparam int DF = 4;
  localparam int DM = 8;
  localparam int DS = 16;
  localparam int NV = 7;
  // {role[3:0], cpol, tx[7:0], rx[7:0]}
  localparam logic [20:0] VEC [NV] = '{
    {4'd0, 1'b0, 8'hA5, 8'h3C},
    {4'd1, 1'b1, 8'h81, 8'h7E},
    {4'd2, 1'b0, 8'hFF, 8'h00},
    {4'd0, 1'b1, 8'h00, 8'hFF},
    {4'd3, 1'b0, 8'h5A, 8'hC3},
    {4'd3, 1'b1, 8'h12, 8'h9B},
    {4'd1, 1'b0, 8'h6D, 8'hB4}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic timer_tick = 1'b0, tick_en = 1'b0;
  logic s_sck = 1'b0, s_sdi = 1'b0, m_sdi = 1'b0, use_s = 1'b0, ss_n = 1'b1;
  logic sck_o, sck_oe, sdo, sdo_oe, port_en, done;
  logic sdi;
  int cyc = 0, done_cnt = 0, checks = 0, errors = 0;

  assign sdi = use_s ? s_sdi : m_sdi;

  spi_port #(.DIV_FAST(DF), .DIV_MID(DM), .DIV_SLOW(DS)) u_spi_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .timer_tick(timer_tick), .sck_i(s_sck),
    .sck_o(sck_o), .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
    .ss_n(ss_n), .port_en(port_en), .done(done));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (done) done_cnt <= done_cnt + 1;
  always @(negedge clk) timer_tick <= tick_en && (cyc % 3 == 0);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  // Master transfer with the bench acting as the far-end slave.
  task automatic m_xfer(input logic [7:0] tx, input logic [7:0] rx, input logic cpol,
                        input bit midwr, output logic [7:0] cap, output int edges,
                        output int cycles, output logic done_after);
    logic prev;
    logic [7:0] r;
    int t0;
    int k;
    prev = sck_o; r = rx; cap = '0; edges = 0; k = 0;
    wr(2'd1, tx);
    t0 = cyc;
    do begin
      @(negedge clk); k++;
      if (midwr && k == 5) begin wr_en = 1'b1; addr = 2'd1; wdata = 8'h99; end
      if (midwr && k == 6) wr_en = 1'b0;
      if (sck_o != prev) begin
        edges++;
        if (sck_o != cpol) begin m_sdi = r[7]; r = r << 1; end
        else cap = {cap[6:0], sdo};
        prev = sck_o;
      end
    end while (!done && k < 4000);
    cycles = cyc - t0;
    @(negedge clk); done_after = done;
  endtask

  // Bench drives SCK as the far-end master, half period of 8 clocks.
  task automatic s_send(input logic [7:0] mosi, input logic cpol, input int nbits,
                        input bit midwr, output logic [7:0] miso);
    miso = '0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); s_sck = ~cpol; s_sdi = mosi[7-i];
      repeat (8) @(negedge clk);
      miso = {miso[6:0], sdo};
      s_sck = cpol;
      if (midwr && i == 3) begin wr_en = 1'b1; addr = 2'd1; wdata = 8'hFF; end
      @(negedge clk); wr_en = 1'b0;
      repeat (6) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d, cap;
    int edges, cycles, dc;
    logic da;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 / R11 reset state
    rd(2'd0, d); chk("R12 reset ctrl", d, 8'h00);
    rd(2'd1, d); chk("R12 reset buffer", d, 8'h00);
    rd(2'd2, d); chk("R12 reset status", d, 8'h00);
    chk("R11 reset pins", {port_en, sck_oe, sdo_oe, done}, 4'b0000);
    wr(2'd0, 8'h34); rd(2'd0, d); chk("R12 ctrl readback", d, 8'h34);

    // Vector table: master roles and both polarities (R1 R2 R3 R4 R5)
    tick_en = 1'b1;
    for (int i = 0; i < NV; i++) begin
      automatic logic [20:0] v = VEC[i];
      automatic logic [3:0] md = v[20:17];
      automatic logic cp = v[16];
      automatic int dv = (md == 4'd0) ? DF : (md == 4'd1) ? DM : DS;
      wr(2'd0, {2'b00, 1'b1, cp, md});
      @(negedge clk);
      chk("R3 idle level", sck_o, cp);
      chk("R3 master drives sck", sck_oe, 1'b1);
      m_xfer(v[15:8], v[7:0], cp, 1'b0, cap, edges, cycles, da);
      chk("R4 sdo bits", cap, v[15:8]);
      chk("R4 sck transitions", edges, 16);
      if (md != 4'd3) chk("R1 transfer cycles", cycles, 8 * dv);
      else chk("R2 tick clocked transfer edges", edges, 16);
      chk("R5 done one cycle", da, 1'b0);
      chk("R3 idle after", sck_o, cp);
      rd(2'd2, d); chk("R5 full set", d[0], 1'b1);
      rd(2'd1, d); chk("R4 rx byte", d, v[7:0]);
      rd(2'd2, d); chk("R5 full cleared", d[0], 1'b0);
    end

    // R2: no tick, no clock
    tick_en = 1'b0;
    wr(2'd0, 8'h23);
    dc = done_cnt;
    wr(2'd1, 8'h0F);
    edges = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (sck_o != 1'b0) edges++; end
    chk("R2 stalled without tick", edges, 0);
    tick_en = 1'b1;
    repeat (80) @(negedge clk);
    chk("R2 completes with ticks", done_cnt - dc, 1);
    rd(2'd1, d);

    // R6 master collision
    wr(2'd0, 8'h20);
    m_xfer(8'hC5, 8'h2B, 1'b0, 1'b1, cap, edges, cycles, da);
    chk("R6 byte continues", cap, 8'hC5);
    rd(2'd2, d); chk("R6 collision flag", d, 8'h05);
    rd(2'd1, d); chk("R6 rx intact", d, 8'h2B);
    wr(2'd2, 8'h04); rd(2'd2, d); chk("R6 collision cleared", d, 8'h00);

    // R8 master never overflows
    m_xfer(8'h11, 8'h22, 1'b0, 1'b0, cap, edges, cycles, da);
    m_xfer(8'h33, 8'h44, 1'b0, 1'b0, cap, edges, cycles, da);
    rd(2'd2, d); chk("R8 no overflow in master", d, 8'h01);
    rd(2'd1, d); chk("R8 newest byte kept", d, 8'h44);

    // R10 slave, select ignored
    use_s = 1'b1; s_sck = 1'b0; ss_n = 1'b1;
    wr(2'd0, 8'h25);
    repeat (4) @(negedge clk);
    chk("R10 sdo driven with ss high", sdo_oe, 1'b1);
    chk("R3 slave does not drive sck", sck_oe, 1'b0);
    wr(2'd1, 8'h96);
    dc = done_cnt;
    s_send(8'h4D, 1'b0, 8, 1'b0, cap);
    chk("R10 slave tx", cap, 8'h96);
    chk("R5 slave done", done_cnt - dc, 1);
    rd(2'd2, d); chk("R5 slave full", d, 8'h01);

    // R7 overflow, byte dropped
    s_send(8'hE1, 1'b0, 8, 1'b0, cap);
    rd(2'd2, d); chk("R7 overflow set", d, 8'h03);
    wr(2'd2, 8'h02); rd(2'd2, d); chk("R7 overflow cleared", d, 8'h01);
    rd(2'd1, d); chk("R7 earlier byte kept", d, 8'h4D);
    s_send(8'h33, 1'b0, 8, 1'b0, cap);
    rd(2'd1, d); chk("R7 next byte after read", d, 8'h33);
    rd(2'd2, d); chk("R7 no new overflow", d, 8'h00);

    // R6 slave collision
    wr(2'd1, 8'hB2);
    s_send(8'h0E, 1'b0, 8, 1'b1, cap);
    chk("R6 slave tx intact", cap, 8'hB2);
    rd(2'd2, d); chk("R6 slave collision", d, 8'h05);
    wr(2'd2, 8'h04); rd(2'd1, d);

    // R9 slave with select
    ss_n = 1'b1;
    wr(2'd0, 8'h24);
    repeat (4) @(negedge clk);
    chk("R9 sdo released", sdo_oe, 1'b0);
    dc = done_cnt;
    s_send(8'h77, 1'b0, 8, 1'b0, cap);
    chk("R9 clocks ignored", done_cnt - dc, 0);
    rd(2'd2, d); chk("R9 buffer untouched", d, 8'h00);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 sdo driven when selected", sdo_oe, 1'b1);
    wr(2'd1, 8'hA7);
    s_send(8'h5E, 1'b0, 8, 1'b0, cap);
    chk("R9 selected tx", cap, 8'hA7);
    rd(2'd1, d); chk("R9 selected rx", d, 8'h5E);
    s_send(8'hF0, 1'b0, 4, 1'b0, cap);
    ss_n = 1'b1; repeat (6) @(negedge clk);
    ss_n = 1'b0; repeat (6) @(negedge clk);
    s_send(8'h71, 1'b0, 8, 1'b0, cap);
    rd(2'd1, d); chk("R9 partial byte discarded", d, 8'h71);

    // R4 slave with idle-high clock
    ss_n = 1'b1; s_sck = 1'b1;
    wr(2'd0, 8'h35);
    repeat (4) @(negedge clk);
    wr(2'd1, 8'h3C);
    s_send(8'hA9, 1'b1, 8, 1'b0, cap);
    chk("R4 slave tx cpol1", cap, 8'h3C);
    rd(2'd1, d); chk("R4 slave rx cpol1", d, 8'hA9);
    use_s = 1'b0; s_sck = 1'b0;

    // R11 disabled and reserved roles
    wr(2'd0, 8'h00);
    dc = done_cnt;
    wr(2'd1, 8'h55);
    repeat (40) @(negedge clk);
    chk("R11 disabled pins", {port_en, sck_oe, sdo_oe}, 3'b000);
    wr(2'd0, 8'h27);
    wr(2'd1, 8'h55);
    repeat (40) @(negedge clk);
    chk("R11 reserved pins", {port_en, sck_oe, sdo_oe}, 3'b000);
    wr(2'd0, 8'h20);
    edges = 0;
    for (int k = 0; k < 30; k++) begin @(negedge clk); if (sck_o != 1'b0) edges++; end
    chk("R11 stale write starts nothing", edges, 0);
    chk("R11 no transfers", done_cnt - dc, 0);
    rd(2'd2, d); chk("R11 status clean", d, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule